// File: doc/BRIEF.md
# Dirty Rectangle Redraw Queue

This block keeps a ring of screen rectangles that have been drawn into and still need to reach the display. Drawing engines (a copy engine, a fill engine) hand over one rectangle per cycle, given by its left edge, top edge, width and height. The push path never stalls. When the ring is overrun, the oldest entries are silently overwritten.

A flush request starts a drain. The stored rectangles leave through a refresh port with a valid/ready handshake, oldest first, until the ring is empty. Each entry leaves exactly as it was stored, with no merging of overlapping areas. If the whole-screen invalidate input is high when a flush is accepted, the whole backlog is dropped in one cycle and nothing is issued, because a full-screen refresh will cover it anyway.

Top module: `dirty_rect_queue`

## Requirements
- R1: After reset, busy and out_valid are low and the ring is empty, so a flush with no pushes issues nothing.
- R2: The ring has DEPTH = 512 slots, a power of two. The read and write indices step by one and wrap from 511 to 0 by dropping the carry bit.
- R3: A push is taken in every cycle that push_valid is high, with no full check. After exactly DEPTH pushes without a drain the ring reads as empty. After DEPTH+1 pushes only the newest rectangle remains.
- R4: A drain issues the entries in the order they were pushed. Each entry's x, y, w and h come out unchanged, overlapping rectangles included, and the drain stops when the read index reaches the write index.
- R5: A flush accepted while invalidate is high moves the read index onto the write index in one cycle. It issues no entry, and busy stays low. A rectangle pushed in that same cycle stays queued.
- R6: While out_valid is high and out_ready is low, out_valid stays high and the rectangle fields hold still, as long as no push arrives.
- R7: busy rises in the cycle after a flush is accepted on a non-empty ring, and it falls after the handshake of the last entry. out_valid equals busy. A flush request that arrives while busy is high is ignored, whatever the level of invalidate.
- R8: Rectangles pushed during a drain join the same drain and are issued before busy falls.
- R9: A flush accepted on an empty ring leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Store the rectangle on push_x..push_h this cycle |
| push_x | input | 12 | Left edge of the pushed rectangle |
| push_y | input | 12 | Top edge of the pushed rectangle |
| push_w | input | 12 | Width of the pushed rectangle |
| push_h | input | 12 | Height of the pushed rectangle |
| invalidate | input | 1 | Whole screen dirty; a flush taken while it is high drops the backlog |
| flush_req | input | 1 | Request a drain; taken only while busy is low |
| out_valid | output | 1 | A rectangle is offered on the refresh port |
| out_ready | input | 1 | The refresh consumer takes the offered rectangle |
| out_x | output | 12 | Left edge of the offered rectangle |
| out_y | output | 12 | Top edge of the offered rectangle |
| out_w | output | 12 | Width of the offered rectangle |
| out_h | output | 12 | Height of the offered rectangle |
| busy | output | 1 | A drain is in progress |

## Verification
A push lands in the ring at the clock edge that samples it. A flush raises busy, and with it out_valid and the head rectangle, one edge after it is sampled. A discard takes effect at that same edge, and the read index advances at each edge that completes a handshake. The bench drives inputs on the falling edge and advances its behavioural model just after each rising edge, using the inputs the design sampled there. It then compares busy, out_valid and the offered rectangle on the next falling edge. This way every comparison falls one edge after its cause. Rectangles taken by handshake are also collected and compared against the lists each directed test expects.

// File: rtl/drq_pkg.sv
package drq_pkg;
  localparam int COORD_W = 12;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] w;
    logic [COORD_W-1:0] h;
  } rect_t;

  localparam int RECT_W = $bits(rect_t);

  // Next slot of a power-of-two ring: the carry past the top bit is dropped.
  function automatic logic [15:0] ring_step(input logic [15:0] idx, input int unsigned depth);
    logic [15:0] msk;
    msk = 16'(depth - 1);
    return (idx + 16'd1) & msk;
  endfunction

  function automatic rect_t make_rect(input logic [COORD_W-1:0] x, input logic [COORD_W-1:0] y,
                                      input logic [COORD_W-1:0] w, input logic [COORD_W-1:0] h);
    rect_t r;
    r.x = x;
    r.y = y;
    r.w = w;
    r.h = h;
    return r;
  endfunction
endpackage

// File: rtl/drq_ring_index.sv
module drq_ring_index #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  import drq_pkg::*;

  logic [15:0] stepped;
  assign stepped = ring_step(16'(idx), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (load)   idx <= load_val;
    else if (step)   idx <= stepped[IDX_W-1:0];
  end
endmodule

// File: rtl/drq_rect_store.sv
module drq_rect_store #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  drq_pkg::rect_t   wdata,
  input  logic [IDX_W-1:0] raddr,
  output drq_pkg::rect_t   rdata
);
  drq_pkg::rect_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/drq_drain_ctrl.sv
module drq_drain_ctrl #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_req,
  input  logic             invalidate,
  input  logic             push_valid,
  input  logic             out_ready,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             busy,
  output logic             flush_take,
  output logic             discard_evt,
  output logic             issue_fire
);
  import drq_pkg::*;

  logic             start_evt;
  logic [IDX_W-1:0] rd_after;
  logic [IDX_W-1:0] wr_after;
  logic [15:0]      rd_inc;
  logic [15:0]      wr_inc;
  logic             busy_d;

  assign rd_inc      = ring_step(16'(rd_idx), DEPTH);
  assign wr_inc      = ring_step(16'(wr_idx), DEPTH);
  assign flush_take  = flush_req && !busy;
  assign discard_evt = flush_take && invalidate;
  assign start_evt   = flush_take && !invalidate && (rd_idx != wr_idx);
  assign issue_fire  = busy && out_ready;
  assign rd_after    = issue_fire ? rd_inc[IDX_W-1:0] : rd_idx;
  assign wr_after    = push_valid ? wr_inc[IDX_W-1:0] : wr_idx;

  always_comb begin
    if (start_evt)  busy_d = (rd_idx != wr_after);
    else if (busy)  busy_d = (rd_after != wr_after);
    else            busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end
endmodule

// File: rtl/dirty_rect_queue.sv
module dirty_rect_queue #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = drq_pkg::COORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [CW-1:0] push_x,
  input  logic [CW-1:0] push_y,
  input  logic [CW-1:0] push_w,
  input  logic [CW-1:0] push_h,
  input  logic          invalidate,
  input  logic          flush_req,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y,
  output logic [CW-1:0] out_w,
  output logic [CW-1:0] out_h,
  output logic          busy
);
  import drq_pkg::*;

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             flush_take;
  logic             discard_evt;
  logic             issue_fire;
  rect_t            push_rect;
  rect_t            head_rect;

  assign push_rect = make_rect(push_x, push_y, push_w, push_h);

  drq_ring_index #(.DEPTH(DEPTH)) u_wr_idx (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
    .step(push_valid), .idx(wr_idx)
  );

  drq_ring_index #(.DEPTH(DEPTH)) u_rd_idx (
    .clk(clk), .rst_n(rst_n), .load(discard_evt), .load_val(wr_idx),
    .step(issue_fire), .idx(rd_idx)
  );

  drq_rect_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_valid), .waddr(wr_idx), .wdata(push_rect),
    .raddr(rd_idx), .rdata(head_rect)
  );

  drq_drain_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .invalidate(invalidate),
    .push_valid(push_valid), .out_ready(out_ready), .rd_idx(rd_idx), .wr_idx(wr_idx),
    .busy(busy), .flush_take(flush_take), .discard_evt(discard_evt), .issue_fire(issue_fire)
  );

  assign out_valid = busy;
  assign out_x     = head_rect.x;
  assign out_y     = head_rect.y;
  assign out_w     = head_rect.w;
  assign out_h     = head_rect.h;
endmodule

// File: rtl/drq_checker.sv
module drq_checker #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = drq_pkg::COORD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             invalidate,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CW-1:0]    out_x,
  input logic [CW-1:0]    out_y,
  input logic [CW-1:0]    out_w,
  input logic [CW-1:0]    out_h,
  input logic             busy,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] wr_idx,
  input logic             flush_take,
  input logic             discard_evt,
  input logic             issue_fire
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DEPTH - 1);

  assert_wr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && wr_idx == TOP) |=> (wr_idx == '0));

  assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

  assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard_evt |=> (!busy && rd_idx == $past(wr_idx)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !push_valid) |=>
      (out_valid && $stable(out_x) && $stable(out_y) && $stable(out_w) && $stable(out_h)));

  assert_rd_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_fire && !discard_evt) |=> $stable(rd_idx));

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_take && !invalidate && !push_valid && rd_idx != wr_idx) |=> busy);

  assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == busy);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !flush_take) |=> !out_valid);
endmodule

bind dirty_rect_queue drq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .invalidate(invalidate),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .out_w(out_w), .out_h(out_h), .busy(busy),
  .rd_idx(rd_idx), .wr_idx(wr_idx), .flush_take(flush_take),
  .discard_evt(discard_evt), .issue_fire(issue_fire)
);

// File: tb/dirty_rect_queue_tb.sv
`timescale 1ns/1ps
module dirty_rect_queue_tb;
  localparam int D  = 512;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [CW-1:0] push_x = '0, push_y = '0, push_w = '0, push_h = '0;
  logic invalidate = 1'b0, flush_req = 1'b0, out_ready = 1'b0;
  logic out_valid, busy;
  logic [CW-1:0] out_x, out_y, out_w, out_h;

  always #2.5 clk = ~clk;

  dirty_rect_queue u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
    .push_x(push_x), .push_y(push_y), .push_w(push_w), .push_h(push_h),
    .invalidate(invalidate), .flush_req(flush_req), .out_valid(out_valid),
    .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_w(out_w),
    .out_h(out_h), .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // behavioural reference: slot array plus two plain integer positions
  logic [4*CW-1:0] m_slot [D];
  int  m_wr = 0, m_rd = 0;
  bit  m_busy = 0;
  logic [4*CW-1:0] got [$];
  logic [4*CW-1:0] want [$];

  function automatic logic [4*CW-1:0] pat(input int n);
    return {CW'(n), CW'(n * 3 + 7), CW'(n + 1), CW'(n ^ 5)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    bit take, start, fire;
    int wr_new, rd_new;
    take  = flush_req && !m_busy;
    start = take && !invalidate && (m_rd != m_wr);
    fire  = m_busy && out_ready;
    if (take && invalidate) m_rd = m_wr;
    rd_new = fire ? (m_rd + 1) % D : m_rd;
    wr_new = push_valid ? (m_wr + 1) % D : m_wr;
    if (push_valid) m_slot[m_wr] = {push_x, push_y, push_w, push_h};
    if (start)       m_busy = (m_rd != wr_new);
    else if (m_busy) m_busy = (rd_new != wr_new);
    else             m_busy = 0;
    m_rd = rd_new;
    m_wr = wr_new;
  endtask

  task automatic compare();
    check(busy == m_busy, "R7 busy", 64'(busy), 64'(m_busy));
    check(out_valid == m_busy, "R7 out_valid", 64'(out_valid), 64'(m_busy));
    if (m_busy)
      check({out_x, out_y, out_w, out_h} == m_slot[m_rd], "R4 head rect",
            64'({out_x, out_y, out_w, out_h}), 64'(m_slot[m_rd]));
  endtask

  // one cycle: inputs already set at a falling edge
  task automatic step();
    if (out_valid && out_ready) got.push_back({out_x, out_y, out_w, out_h});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    push_valid = 0;
    flush_req  = 0;
  endtask

  task automatic push(input int n);
    {push_x, push_y, push_w, push_h} = pat(n);
    push_valid = 1;
    want.push_back(pat(n));
  endtask

  task automatic drain(input bit stall_pattern);
    int k = 0;
    while (busy) begin
      out_ready = stall_pattern ? ((k % 3) != 1) : 1'b1;
      k++;
      step();
    end
    out_ready = 0;
  endtask

  task automatic check_list(input string tag);
    check(got.size() == want.size(), tag, 64'(got.size()), 64'(want.size()));
    foreach (want[i])
      if (i < got.size()) check(got[i] == want[i], tag, 64'(got[i]), 64'(want[i]));
    got.delete();
    want.delete();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, then a flush on the empty ring (R9)
    check(busy == 0 && out_valid == 0, "R1 reset idle", 64'({busy, out_valid}), 64'(0));
    flush_req = 1; step();
    check(busy == 0, "R9 flush on empty ring", 64'(busy), 64'(0));
    step();

    // R4 order with overlapping rects, R6 stalls on the refresh port
    for (int i = 0; i < 5; i++) begin push(i == 2 ? 1 : 10 + i); step(); end
    flush_req = 1; step();
    check(busy == 1, "R7 busy after flush", 64'(busy), 64'(1));
    drain(1);
    check_list("R4 drain order");

    // R5: invalidate discard, push in same cycle survives
    for (int i = 0; i < 3; i++) begin push(40 + i); step(); end
    want.delete();
    invalidate = 1; flush_req = 1; push(77); step();
    invalidate = 0;
    check(busy == 0, "R5 discard keeps busy low", 64'(busy), 64'(0));
    step();
    check(out_valid == 0, "R5 nothing issued", 64'(out_valid), 64'(0));
    push(78); step();
    flush_req = 1; step();
    drain(0);
    check_list("R5 only post-discard entries");

    // R7 flush+invalidate while busy ignored; R8 pushes during drain
    for (int i = 0; i < 4; i++) begin push(100 + i); step(); end
    flush_req = 1; step();
    invalidate = 1; flush_req = 1; out_ready = 1; push(200); step();
    invalidate = 0;
    push(201); step();
    drain(0);
    check_list("R7 R8 ignored flush and late pushes");

    // R2: cross the 511 -> 0 boundary in one drain
    for (int i = 0; i < 505; i++) begin push(300 + i); step(); end
    flush_req = 1; step();
    drain(1);
    check_list("R2 wrap drain");

    // R3: exactly DEPTH pushes look empty
    for (int i = 0; i < D; i++) begin push(1000 + i); step(); end
    want.delete();
    flush_req = 1; step();
    check(busy == 0, "R3 full lap reads empty", 64'(busy), 64'(0));
    // R3: one more push leaves only the newest
    push(3000); step();
    flush_req = 1; step();
    drain(0);
    check_list("R3 overwrite keeps newest");

    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule